// File: doc/BRIEF.md
# Serial EEPROM Single-Byte Write Sequencer

This block is a hardware master for a serial (SPI mode 0) EEPROM. It stores one byte at a 16-bit byte address, and it needs no software to toggle the pins. A request carries the address and the data byte. Once the block accepts a request, it runs three kinds of chip-select frames in a fixed order:

1. It reads the device status repeatedly until the device reports that it is idle.
2. It sends a write-enable command in a frame of its own.
3. It sends the write command, followed by the address and the data.

Every field is shifted most significant bit first. The block drives an active-low chip select, the serial clock and the serial data output, and it samples the serial data input. When the write is complete it pulses `done`. If the device stays busy past a programmable cycle budget, it pulses `err` and abandons the write.

The serial clock is derived from the system clock. Each half-period of the serial clock lasts `CLK_DIV` system cycles. The timeout budget is counted in system cycles from the accepted request. The budget is compared only at the end of each status frame that reports the device busy.

Top module: `eeprom_byte_writer`

## Requirements
- R1: After reset, `cs_n` is 1 and `sck`, `busy`, `done` and `err` are all 0.
- R2: When `req_valid` is high while `busy` is low, the block accepts the request and `busy` is 1 on the next cycle. While `busy` is high, `req_valid` is ignored: no extra frame is issued and the latched address and data do not change.
- R3: Each status frame holds 16 serial clocks. The first 8 bits carry the opcode 0x05 MSB first. The block captures 8 status bits from `miso` over the last 8 clocks, MSB first, sampling each bit at the end of the low half that precedes its rising edge.
- R4: Bit 0 of the captured status is the device-busy flag. While it reads 1, a new status frame follows. When it reads 0, the block goes on to the write-enable frame.
- R5: The write-enable frame holds exactly 8 clocks carrying the opcode 0x06. Chip select is released right after the 8th clock.
- R6: The write frame holds exactly 32 clocks, in this order: the opcode 0x02, address bits 15 down to 0, then data bits 7 down to 0.
- R7: Chip select stays high for at least 2*CLK_DIV system cycles between consecutive frames of one write. `sck` is low whenever `cs_n` is high.
- R8: Each bit is placed on `mosi` while `sck` is low. `sck` then stays high for exactly CLK_DIV cycles, and `mosi` does not change during that time.
- R9: `done` pulses for exactly one cycle, one cycle after chip select rises at the end of the write frame. `busy` is already 0 in that cycle.
- R10: Suppose a status frame ends with the busy flag set, and at least `tmo_limit` cycles have passed since acceptance. Then `err` pulses for one cycle, `busy` drops, and no further frame is issued. A `tmo_limit` of 0 aborts after the first busy status.
- R11: `done` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request strobe |
| req_addr | input | ADDR_W | EEPROM byte address |
| req_data | input | DATA_W | Byte to store |
| tmo_limit | input | TMO_W | Busy-poll timeout budget in system cycles |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle write-complete pulse |
| err | output | 1 | One-cycle timeout-abort pulse |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A wrong sequencer state shows up at the pins within one serial bit. An opcode out of place, a bit count off by one or a frame in the wrong order is visible in the captured frame bits as soon as chip select rises. A mis-sampled status bit appears as one poll too many or too few. A broken timeout shows as a missing or early `err`, and the bench can compute the number of polls that should come before it. Bit-rate errors appear within a single clock high phase, and a short inter-frame gap appears at the next falling edge of chip select.

// File: rtl/eebw_pkg.sv
package eebw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL, ST_PGAP, ST_RGAP, ST_WREN, ST_EGAP, ST_WRITE
  } st_e;

  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_STORE  = 8'h02;
  localparam int         POLL_BITS = 16;
  localparam int         WEN_BITS  = 8;

  // cycles of chip-select-high between frames: one serial period
  function automatic int gap_cycles(input int div);
    return 2 * div;
  endfunction

  // device-busy flag inside the status byte
  function automatic logic dev_busy(input logic [7:0] status);
    return status[0];
  endfunction
endpackage

// File: rtl/eebw_tick.sv
module eebw_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eebw_frame.sv
module eebw_frame #(
  parameter int W   = 32,
  parameter int DIV = 4,
  localparam int NW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] nbits,
  input  logic [W-1:0]  word,
  input  logic          miso,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi,
  output logic [7:0]    rx,
  output logic          fdone
);
  logic          active, phase, tick;
  logic [W-1:0]  sh;
  logic [NW-1:0] bcnt, nb_q;

  eebw_tick #(.DIV(DIV)) tick_i (.clk(clk), .rst_n(rst_n), .en(active), .tick(tick));

  assign cs_n = !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= 1'b0; sck <= 1'b0; mosi <= 1'b0;
      sh <= '0; bcnt <= '0; nb_q <= '0; rx <= '0; fdone <= 1'b0;
    end else begin
      fdone <= 1'b0;
      if (start && !active) begin
        active <= 1'b1; phase <= 1'b0; sck <= 1'b0;
        sh <= word; mosi <= word[W-1]; bcnt <= '0; nb_q <= nbits;
      end else if (active && tick) begin
        if (!phase) begin
          sck   <= 1'b1;
          phase <= 1'b1;
          rx    <= {rx[6:0], miso};   // sample at end of low half
        end else begin
          sck   <= 1'b0;
          phase <= 1'b0;
          if (bcnt == nb_q - 1'b1) begin
            active <= 1'b0;
            fdone  <= 1'b1;
            mosi   <= 1'b0;
          end else begin
            sh   <= sh << 1;
            mosi <= sh[W-2];
            bcnt <= bcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_byte_writer.sv
module eeprom_byte_writer
  import eebw_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int TMO_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int FRAME_W = 8 + ADDR_W + DATA_W;
  localparam int NW      = $clog2(FRAME_W + 1);
  localparam int GAP     = gap_cycles(CLK_DIV);
  localparam int GW      = $clog2(GAP + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP - 1);

  st_e               st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [GW-1:0]     gcnt;
  logic [7:0]        status;

  // named internal events
  logic          accept, fdone, gap_end, poll_ready, tmo_hit, fstart;
  logic [NW-1:0] fnb;
  logic [FRAME_W-1:0] fword;

  assign busy       = (st != ST_IDLE);
  assign accept     = (st == ST_IDLE) && req_valid;
  assign gap_end    = (gcnt == GAP_LAST);
  assign poll_ready = !dev_busy(status);
  assign tmo_hit    = (tmo_cnt >= tmo_limit);

  always_comb begin
    fstart = 1'b0;
    fnb    = NW'(POLL_BITS);
    fword  = {OP_STATUS, {(FRAME_W-8){1'b0}}};
    unique case (st)
      ST_IDLE: fstart = req_valid;
      ST_PGAP: fstart = gap_end;
      ST_RGAP: begin
        fstart = gap_end;
        fnb    = NW'(WEN_BITS);
        fword  = {OP_WEN, {(FRAME_W-8){1'b0}}};
      end
      ST_EGAP: begin
        fstart = gap_end;
        fnb    = NW'(FRAME_W);
        fword  = {OP_STORE, addr_q, data_q};
      end
      default: ;
    endcase
  end

  eebw_frame #(.W(FRAME_W), .DIV(CLK_DIV)) frame_i (
    .clk(clk), .rst_n(rst_n), .start(fstart), .nbits(fnb), .word(fword),
    .miso(miso), .cs_n(cs_n), .sck(sck), .mosi(mosi), .rx(status), .fdone(fdone)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; addr_q <= '0; data_q <= '0; tmo_cnt <= '0;
      gcnt <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (busy && tmo_cnt != '1) tmo_cnt <= tmo_cnt + 1'b1;
      if (st == ST_PGAP || st == ST_RGAP || st == ST_EGAP) gcnt <= gcnt + 1'b1;
      else gcnt <= '0;
      unique case (st)
        ST_IDLE: if (accept) begin
          st <= ST_POLL; addr_q <= req_addr; data_q <= req_data; tmo_cnt <= '0;
        end
        ST_POLL: if (fdone) begin
          if (poll_ready)   st <= ST_RGAP;
          else if (tmo_hit) begin st <= ST_IDLE; err <= 1'b1; end
          else              st <= ST_PGAP;
        end
        ST_PGAP:  if (gap_end) st <= ST_POLL;
        ST_RGAP:  if (gap_end) st <= ST_WREN;
        ST_WREN:  if (fdone)   st <= ST_EGAP;
        ST_EGAP:  if (gap_end) st <= ST_WRITE;
        ST_WRITE: if (fdone) begin st <= ST_IDLE; done <= 1'b1; end
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eebw_checker.sv
module eebw_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic err,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic accept,
  input logic fdone
);
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && cs_n && $past(fdone)));
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && cs_n));
  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  p_frame_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind eeprom_byte_writer eebw_checker chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi), .accept(accept), .fdone(fdone)
);

// File: tb/eeprom_byte_writer_tb_top.sv
module eeprom_byte_writer_tb_top;
  localparam int DIV = 4;
  localparam int TP  = 8;   // ns per system cycle

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, miso = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [23:0] tmo_limit = '0;
  logic busy, done, err, cs_n, sck, mosi;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  eeprom_byte_writer #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .tmo_limit(tmo_limit), .busy(busy), .done(done),
    .err(err), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int          fr_cnt = 0, bit_n = 0, busy_target = 0, polls_seen = 0;
  int          fr_n [64];
  logic [31:0] fr_v [64];
  logic [31:0] shreg = '0;
  logic [7:0]  op_q = '0, stat = '0;
  time         t_rise = 0, t_hi = 0;
  bit          in_seq = 1'b0;

  always @(negedge cs_n) begin
    if (in_seq && fr_cnt > 0)
      check(($time - t_rise) >= 2*DIV*TP, "R7 gap", $time - t_rise, 2*DIV*TP);
    bit_n = 0; shreg = '0; op_q = '0;
    stat = 8'($urandom);
    stat[0] = (polls_seen < busy_target);
    miso = 1'b0;
  end

  always @(posedge sck) begin
    t_hi = $time;
    shreg = {shreg[30:0], mosi};
    bit_n++;
    if (bit_n == 8) op_q = shreg[7:0];
  end

  always @(negedge sck) begin
    check(($time - t_hi) == DIV*TP, "R8 high time", $time - t_hi, DIV*TP);
    if (!cs_n && op_q == 8'h05 && bit_n >= 8 && bit_n < 16) miso = stat[15-bit_n];
    else miso = 1'b0;
  end

  always @(posedge cs_n) begin
    t_rise = $time;
    if (fr_cnt < 64) begin fr_n[fr_cnt] = bit_n; fr_v[fr_cnt] = shreg; end
    if (op_q == 8'h05 && bit_n == 16) polls_seen++;
    fr_cnt++;
    miso = 1'b0;
  end

  // ---------------- scenario ----------------
  function automatic int exp_polls_tmo(input int k);
    return k + 1;
  endfunction

  task automatic run_write(input logic [15:0] a, input logic [7:0] d, input int bp,
                           input logic [23:0] lim, input bit exp_err, input int npoll,
                           input bit poke);
    int n;
    int base;
    busy_target = bp; polls_seen = 0; fr_cnt = 0; in_seq = 1'b1;
    @(negedge clk);
    req_addr = a; req_data = d; tmo_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R2 accept", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1'b1; req_addr = ~a; req_data = ~d;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && !err && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check(n < 40000, "R9 completion", n, 0);
    check(!(done && err), "R11 exclusive", {done, err}, 0);
    check(err == exp_err, exp_err ? "R10 err" : "R9 done", err, exp_err);
    check(done == !exp_err, "R9 done level", done, !exp_err);
    check(busy == 1'b0, "R9/R10 busy low at end", busy, 0);
    check(cs_n == 1'b1, "R7 cs idle at end", cs_n, 1);
    @(negedge clk);
    check(!done && !err, "R9 one-cycle pulse", {done, err}, 0);
    check(fr_cnt == npoll + (exp_err ? 0 : 2), "R4/R10 frame count", fr_cnt, npoll + (exp_err ? 0 : 2));
    for (int i = 0; i < npoll && i < 62; i++) begin
      check(fr_n[i] == 16, "R3 poll length", fr_n[i], 16);
      check(fr_v[i][15:8] == 8'h05, "R3 poll opcode", fr_v[i][15:8], 8'h05);
    end
    base = npoll;
    if (!exp_err && base < 62) begin
      check(fr_n[base] == 8, "R5 wren length", fr_n[base], 8);
      check(fr_v[base][7:0] == 8'h06, "R5 wren opcode", fr_v[base][7:0], 8'h06);
      check(fr_n[base+1] == 32, "R6 write length", fr_n[base+1], 32);
      check(fr_v[base+1] == {8'h02, a, d}, "R6 write content", fr_v[base+1], {8'h02, a, d});
    end
    n = fr_cnt;
    repeat (40) @(negedge clk);
    check(fr_cnt == n && cs_n && !busy, "R2/R10 no further frames", fr_cnt, n);
    in_seq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int bp;
    int k;
    logic [23:0] lim;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !busy && !done && !err, "R1 reset", {cs_n, sck, busy, done, err}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !sck && !busy, "R1 after release", {cs_n, sck, busy}, 3'b100);
    // directed corners
    run_write(16'h0000, 8'h00, 0, 24'hFFFFFF, 1'b0, 1, 1'b0);
    run_write(16'hFFFF, 8'hFF, 0, 24'hFFFFFF, 1'b0, 1, 1'b1);  // R2 ignored request
    run_write(16'hA55A, 8'h3C, 3, 24'hFFFFFF, 1'b0, 4, 1'b1);  // R4 busy polls
    run_write(16'h1234, 8'h81, 5, 24'd0, 1'b1, 1, 1'b0);       // R10 zero budget
    // R10 timeout after k+1 polls: budget midway in the (k+1)th poll frame
    for (int t = 0; t < 4; t++) begin
      k   = int'($urandom_range(1, 4));
      lim = 24'(k * (32*DIV + 2*DIV) + 16*DIV);
      run_write(16'($urandom), 8'($urandom), 50, lim, 1'b1, exp_polls_tmo(k), 1'b0);
    end
    // random successful writes
    for (int t = 0; t < 25; t++) begin
      bp = int'($urandom_range(0, 5));
      run_write(16'($urandom), 8'($urandom), bp, 24'hFFFFFF, 1'b0, bp + 1, t[0]);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule